// File: doc/BRIEF.md
# Edge-selectable GPIO interrupt detector

This block watches the synchronised input pins of a GPIO expander and decides, line by line, when an interrupt is pending. Each line has its own enable bit, a 2-bit event select and a latch bit. Pending events are held in a per-line status register. An active-low interrupt output summarises every enabled pending line.

The block does no register decoding. The surrounding register file hands it the configuration values and single-cycle strobes. One strobe marks a read of the input port, which is the clearing read. A second strobe marks a read of the input-status view, which does not clear. A third strobe, with its data, marks a write to the per-line clear register.

Each line also keeps a reference value, captured at the last clearing read. In level mode a line is compared against this reference. In every mode the reference decides when a non-latched line falls back to idle.

Top module: `gpio_evt_irq`

## Requirements
- R1: After reset, status is all zero, `irq_n_o` is 1, `rd_data_o` is zero, and every reference value and previous-sample value is 0. As a result, a level-mode line that reads 1 after reset is an event.
- R2: A line whose `mask_i` bit is 0 never sets its status bit. A `mask_i` bit of 1 lets that line's events set status.
- R3: The select for line i is `edge_sel_i[2i+1:2i]`, with four encodings:
  - 0: level, where the event is the pin differing from its reference.
  - 1: rising edge, meaning a 0 to 1 change from the previous cycle's sample.
  - 2: falling edge, the 1 to 0 change.
  - 3: either edge.
- R4: A status bit is set at the first clock edge after the event appears at the pins. `irq_n_o` is 0 exactly when some status bit has its `mask_i` bit set.
- R5: A line with its `latch_i` bit at 1 keeps its status set until a clearing read or a clear write, even if the pin returns to its reference.
- R6: A line with its `latch_i` bit at 0 clears its status at any edge where its pin equals its reference. A new event at that same edge wins and keeps the bit set.
- R7: When `clr_wr_i` is 1, each line with a 1 in `clr_data_i` has its status cleared and other lines keep theirs. An event on a cleared line at that same edge wins.
- R8: When `in_rd_i` is 1, the following happen at that edge:
  - All status bits clear.
  - Every reference takes the current pin value.
  - `rd_data_o` takes the pins.
  - Level-mode events are not recorded, while edge-mode events still set status.
- R9: When `stat_rd_i` is 1, `rd_data_o` takes the current pin values and neither status nor any reference changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | LINES | Synchronised input pins |
| mask_i | input | LINES | Per-line interrupt enable, 1 enables |
| edge_sel_i | input | 2*LINES | Per-line event select, two bits per line |
| latch_i | input | LINES | Per-line latch enable |
| clr_wr_i | input | 1 | Strobe: write to the clear register |
| clr_data_i | input | LINES | Clear write data, 1 clears that line |
| in_rd_i | input | 1 | Strobe: clearing read of the input port |
| stat_rd_i | input | 1 | Strobe: non-clearing read of the input-status view |
| status_o | output | LINES | Per-line pending status |
| irq_n_o | output | 1 | Active-low interrupt request |
| rd_data_o | output | LINES | Pin values captured at the last read strobe |

## Verification
The assertions take the strobes to be single-cycle pulses that sample the same cycle's configuration. Several properties guard themselves on particular configurations so that they avoid competing event sources: an all-zero mask, or all lines latched. The stimulus reaches those guarded states in a directed phase, then moves to a random phase. The random phase changes pins, masks, selects and latches every cycle and fires reads and clear writes at random, including on the same edge as events.

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq #(
  parameter int LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINES-1:0]   pin_i,
  input  logic [LINES-1:0]   mask_i,
  input  logic [2*LINES-1:0] edge_sel_i,
  input  logic [LINES-1:0]   latch_i,
  input  logic               clr_wr_i,
  input  logic [LINES-1:0]   clr_data_i,
  input  logic               in_rd_i,
  input  logic               stat_rd_i,
  output logic [LINES-1:0]   status_o,
  output logic               irq_n_o,
  output logic [LINES-1:0]   rd_data_o
);
  logic [LINES-1:0] prev_q, ref_q, stat_q, rd_q, hit, drop;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_comb begin
      case (edge_sel_i[2*i +: 2])
        2'd0:    hit[i] = (pin_i[i] ^ ref_q[i]) & ~in_rd_i;
        2'd1:    hit[i] = pin_i[i] & ~prev_q[i];
        2'd2:    hit[i] = ~pin_i[i] & prev_q[i];
        default: hit[i] = pin_i[i] ^ prev_q[i];
      endcase
    end
  end

  assign drop = {LINES{in_rd_i}}
              | (clr_data_i & {LINES{clr_wr_i}})
              | (~latch_i & ~(pin_i ^ ref_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      ref_q  <= '0;
      stat_q <= '0;
      rd_q   <= '0;
    end else begin
      prev_q <= pin_i;
      stat_q <= (stat_q & ~drop) | (hit & mask_i);
      if (in_rd_i) ref_q <= pin_i;
      if (in_rd_i || stat_rd_i) rd_q <= pin_i;
    end
  end

  assign status_o  = stat_q;
  assign rd_data_o = rd_q;
  assign irq_n_o   = ~|(stat_q & mask_i);
endmodule

// File: rtl/gpio_evt_irq_chk.sv
module gpio_evt_irq_chk #(
  parameter int LINES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LINES-1:0]   pin_i,
  input logic [LINES-1:0]   mask_i,
  input logic [LINES-1:0]   latch_i,
  input logic               clr_wr_i,
  input logic [LINES-1:0]   clr_data_i,
  input logic               in_rd_i,
  input logic               stat_rd_i,
  input logic [LINES-1:0]   status_o,
  input logic [LINES-1:0]   rd_data_o
);
  a_r2_masked_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i == '0) |=> ((status_o & ~$past(status_o)) == '0));

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rd_i && mask_i == '0) |=> (status_o == '0));

  a_r7_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr_i && mask_i == '0) |=> ((status_o & $past(clr_data_i)) == '0));

  a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_i == '1 && !in_rd_i && !clr_wr_i) |=> (($past(status_o) & ~status_o) == '0));

  a_r9_status_view: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && !in_rd_i) |=> (rd_data_o == $past(pin_i)));
endmodule

bind gpio_evt_irq gpio_evt_irq_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .mask_i(mask_i), .latch_i(latch_i),
  .clr_wr_i(clr_wr_i), .clr_data_i(clr_data_i), .in_rd_i(in_rd_i),
  .stat_rd_i(stat_rd_i), .status_o(status_o), .rd_data_o(rd_data_o)
);

// File: tb/gpio_evt_irq_test.sv
`timescale 1ns/1ps
module gpio_evt_irq_test;
  logic clk = 0, rst_n = 0;
  logic [7:0] pin = 0, mask = 0, latch = 0, clr_data = 0;
  logic [15:0] sel = 0;
  logic clr_wr = 0, in_rd = 0, stat_rd = 0;
  logic [7:0] status, rd_data;
  logic irq_n;
  int total = 0, bad = 0;
  string cur_req = "R1";
  bit finished = 0;

  gpio_evt_irq #(.LINES(8)) uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .mask_i(mask), .edge_sel_i(sel),
    .latch_i(latch), .clr_wr_i(clr_wr), .clr_data_i(clr_data), .in_rd_i(in_rd),
    .stat_rd_i(stat_rd), .status_o(status), .irq_n_o(irq_n), .rd_data_o(rd_data)
  );

  always #2 clk = ~clk;

  logic [7:0] m_stat = 0, m_ref = 0, m_prev = 0, m_rd = 0, nstat;
  int s;
  bit hit;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = 0; m_ref = 0; m_prev = 0; m_rd = 0;
    end else begin
      nstat = m_stat;
      for (int i = 0; i < 8; i++) begin
        s = int'(sel[2*i +: 2]);
        if (s == 0)      hit = (pin[i] != m_ref[i]) && !in_rd;
        else if (s == 1) hit = pin[i] && !m_prev[i];
        else if (s == 2) hit = !pin[i] && m_prev[i];
        else             hit = pin[i] != m_prev[i];
        if (in_rd) nstat[i] = 0;
        if (clr_wr && clr_data[i]) nstat[i] = 0;
        if (!latch[i] && pin[i] == m_ref[i]) nstat[i] = 0;
        if (hit && mask[i]) nstat[i] = 1;
      end
      if (in_rd) m_ref = pin;
      if (in_rd || stat_rd) m_rd = pin;
      m_prev = pin;
      m_stat = nstat;
    end
  end

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk(cur_req, "model status", status, m_stat);
    chk("R4", "model irq_n", {7'd0, irq_n}, {7'd0, ~|(m_stat & mask)});
    chk(cur_req, "model rd_data", rd_data, m_rd);
  end

  task automatic tick;
    @(negedge clk);
    #1;
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset status", status, 8'h00);
    chk("R1", "reset irq_n", {7'd0, irq_n}, 8'h01);
    chk("R1", "reset rd_data", rd_data, 8'h00);
    #1;
    cur_req = "R3"; mask = 8'hFF; sel = 16'h5555; latch = 8'hFF; pin = 8'h01;
    @(negedge clk);
    chk("R3", "rising sets", status, 8'h01);
    chk("R4", "irq low", {7'd0, irq_n}, 8'h00);
    #1; cur_req = "R5"; pin = 8'h00;
    @(negedge clk); chk("R5", "latched holds", status, 8'h01);
    #1; cur_req = "R7"; clr_wr = 1; clr_data = 8'h01;
    @(negedge clk); chk("R7", "clear write", status, 8'h00);
    chk("R4", "irq high", {7'd0, irq_n}, 8'h01);
    #1; clr_wr = 0; clr_data = 0; cur_req = "R2"; mask = 8'hFD; pin = 8'h02;
    @(negedge clk); chk("R2", "masked line", status, 8'h00);
    #1; pin = 8'h06;
    @(negedge clk); chk("R2", "enabled line", status, 8'h04);
    #1; cur_req = "R9"; stat_rd = 1;
    @(negedge clk); chk("R9", "status view keeps", status, 8'h04);
    chk("R9", "status view data", rd_data, 8'h06);
    #1; stat_rd = 0; cur_req = "R8"; in_rd = 1;
    @(negedge clk); chk("R8", "read clears", status, 8'h00);
    chk("R8", "read data", rd_data, 8'h06);
    #1; in_rd = 0; cur_req = "R3"; sel = 16'h0000; latch = 8'h00; mask = 8'hFF; pin = 8'h07;
    @(negedge clk); chk("R3", "level event", status, 8'h01);
    #1; cur_req = "R6"; pin = 8'h06;
    @(negedge clk); chk("R6", "return clears", status, 8'h00);
    #1; cur_req = "R3"; sel = 16'hAAAA; pin = 8'h04;
    @(negedge clk); chk("R3", "falling sets", status, 8'h02);
    #1; cur_req = "R6"; sel = 16'hFFFF; pin = 8'h06;
    @(negedge clk); chk("R6", "event beats return", status, 8'h02);
    #1; cur_req = "R7"; clr_wr = 1; clr_data = 8'h02; pin = 8'h04;
    @(negedge clk); chk("R7", "event beats clear", status, 8'h02);
    #1; clr_wr = 0; clr_data = 0;
    cur_req = "R4";
    for (int k = 0; k < 400; k++) begin
      pin = 8'($urandom); mask = 8'($urandom); sel = 16'($urandom);
      latch = 8'($urandom); clr_data = 8'($urandom);
      clr_wr = ($urandom % 4) == 0;
      in_rd = ($urandom % 8) == 0;
      stat_rd = ($urandom % 8) == 0;
      tick();
    end
    clr_wr = 0; in_rd = 0; stat_rd = 0;
    rst_n = 0; mask = 8'hFF; sel = 0; latch = 8'hFF; pin = 0;
    tick(); tick();
    rst_n = 1; cur_req = "R1"; pin = 8'h10;
    @(negedge clk); chk("R1", "reference zero after reset", status, 8'h10);
    #1;
    tick();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule